// File: doc/BRIEF.md
# Serial Management Register Slave with Interrupt

This block is the slave end of a two-wire management link. A controller clocks serial frames on `mdc` and moves data on a shared, open line that this block sees as `mdio_in` and drives through `mdio_out` with the enable `mdio_oe`. The block watches every frame and acts only on those that carry its own 5-bit address, which comes from the `phy_addr` straps. Read frames return one 16-bit register. Write frames update one register.

The bank holds fourteen 16-bit registers. One of them is an interrupt register. Its upper byte holds software-written enable bits. Its lower byte holds sticky status bits, which one-cycle event pulses from the core set. Reading that register clears the status byte. The `irq_pin` output signals that an enabled status bit is set, and one bit of a separate control register chooses whether that level is active high or active low.

All logic runs on the rising edge of `mdc`. Event pulses must be synchronous to `mdc` and last one cycle.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is at least 32 ones, start bits 0 then 1, opcode 10 (read) or 01 (write), 5 device-address bits, 5 register-address bits, 2 turnaround bits and 16 data bits, all MSB first. On a matched read, `mdio_out` carries data bit 15 in the period after the second turnaround bit and one lower bit in each following period.
- R2: On a matched read, `mdio_oe` rises after the edge that samples the first turnaround bit and falls after the edge that samples the last data bit, for 17 periods in all. `mdio_out` is 0 in the first of those periods. Otherwise `mdio_oe` is 0.
- R3: Frames whose device address differs from `phy_addr` never drive the line and change no register.
- R4: Registers at addresses 0 to 6 and 25 to 31 exist. A matched write stores its 16 data bits there, with the exception given in R6 for address 27.
- R5: Any other address reads as 0, with the line still driven, and ignores writes.
- R6: Address 27 is the interrupt register. Bits 15:8 are enable bits that software can write. Bits 7:0 are status bits: `core_evt` bit i sets status bit i, writes do not affect them, and they stay set until cleared.
- R7: A matched read of address 27 returns the value held before the clearing edge and then clears all status bits. An event sampled at the clearing edge remains set.
- R8: The interrupt is pending when any status bit and its enable bit are both 1. Bit 9 of register 31 selects the pin level: when it is 1, `irq_pin` equals the pending flag; when it is 0, `irq_pin` is the inverse of the pending flag.
- R9: A frame with fewer than 32 preamble ones, or with opcode 00 or 11, is dropped without effect.
- R10: After reset all registers are 0, `mdio_oe` is 0 and `irq_pin` is 1.
- R11: `basic_ctrl` always shows the contents of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Sampled level of the shared data line |
| phy_addr | input | 5 | Strapped device address |
| core_evt | input | 8 | One-cycle event pulses, one per status bit |
| mdio_out | output | 1 | Data driven onto the line |
| mdio_oe | output | 1 | Line drive enable |
| basic_ctrl | output | 16 | Contents of register 0 |
| irq_pin | output | 1 | Interrupt output with programmable level |

## Verification
The bench targets the edges of the drive window. A slave that is one period late or early would corrupt the turnaround zero or drop the last data bit, and the per-period comparison of `mdio_oe` and `mdio_out` catches either. It pulses an event exactly at the clearing edge of an interrupt read. A design that clears after setting would lose that event, and the next read would show 0 instead of the event bit. It also sends frames to a foreign address, an absent register, with a 31-bit preamble and with an illegal opcode. A design that decodes loosely would write or drive on one of these, and the read-backs that follow expose it. Finally it toggles the polarity bit and the enable byte while a status bit is set, which exposes an inverted pin level or a status byte that software can write.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  localparam int AW    = 5;
  localparam int DW    = 16;
  localparam int EVT_W = DW / 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_OP, PH_PHY, PH_REG, PH_TA, PH_DATA
  } phase_e;

  // address decode of the populated part of the map
  function automatic logic reg_present(input logic [AW-1:0] a,
                                       input int lo_last, input int hi_first);
    return (int'(a) <= lo_last) || (int'(a) >= hi_first);
  endfunction

  // clear is applied before new events are merged in
  function automatic logic [EVT_W-1:0] status_next(input logic [EVT_W-1:0] cur,
                                                   input logic [EVT_W-1:0] evt,
                                                   input logic clr);
    return (clr ? '0 : cur) | evt;
  endfunction

  function automatic logic irq_level(input logic pend, input logic act_high);
    return act_high ? pend : ~pend;
  endfunction
endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mdio_in,
  input  logic [AW-1:0] my_addr,
  input  logic [DW-1:0] rd_data,
  output logic          mdio_out,
  output logic          mdio_oe,
  output logic          rd_go,
  output logic          wr_go,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] wr_data
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int CW  = $clog2(DW) + 1;
  localparam logic [PCW-1:0] PRE_MAX = PCW'(PRE_LEN);

  phase_e          phase;
  logic [PCW-1:0]  pre_cnt;
  logic [CW-1:0]   bit_cnt;
  logic            op_hi, is_read, hit_q, oe_q, out_q;
  logic [AW-1:0]   phy_sh, reg_sh;
  logic [DW-1:0]   data_sh;

  assign rd_go    = (phase == PH_TA) && (bit_cnt == '0) && hit_q && is_read;
  assign wr_go    = (phase == PH_DATA) && (bit_cnt == CW'(DW-1)) && hit_q && !is_read;
  assign wr_data  = {data_sh[DW-2:0], mdio_in};
  assign reg_addr = reg_sh;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      pre_cnt <= '0;
      bit_cnt <= '0;
      op_hi   <= 1'b0;
      is_read <= 1'b0;
      hit_q   <= 1'b0;
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      phy_sh  <= '0;
      reg_sh  <= '0;
      data_sh <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (mdio_in) begin
            if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
          end else if (pre_cnt == PRE_MAX) begin
            phase   <= PH_START;
            pre_cnt <= '0;
          end else begin
            pre_cnt <= '0;
          end
        end
        PH_START: begin
          bit_cnt <= '0;
          phase   <= mdio_in ? PH_OP : PH_IDLE;
        end
        PH_OP: begin
          if (bit_cnt == '0) begin
            op_hi   <= mdio_in;
            bit_cnt <= CW'(1);
          end else begin
            bit_cnt <= '0;
            if (op_hi != mdio_in) begin
              is_read <= op_hi;
              phase   <= PH_PHY;
            end else begin
              phase <= PH_IDLE;
            end
          end
        end
        PH_PHY: begin
          phy_sh <= {phy_sh[AW-2:0], mdio_in};
          if (bit_cnt == CW'(AW-1)) begin
            bit_cnt <= '0;
            phase   <= PH_REG;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        PH_REG: begin
          reg_sh <= {reg_sh[AW-2:0], mdio_in};
          if (bit_cnt == CW'(AW-1)) begin
            bit_cnt <= '0;
            phase   <= PH_TA;
            hit_q   <= (phy_sh == my_addr);
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        PH_TA: begin
          if (bit_cnt == '0) begin
            bit_cnt <= CW'(1);
            if (rd_go) begin
              oe_q    <= 1'b1;
              out_q   <= 1'b0;
              data_sh <= rd_data;
            end
          end else begin
            bit_cnt <= '0;
            phase   <= PH_DATA;
            out_q   <= data_sh[DW-1];
            data_sh <= {data_sh[DW-2:0], mdio_in};
          end
        end
        PH_DATA: begin
          out_q   <= data_sh[DW-1];
          data_sh <= {data_sh[DW-2:0], mdio_in};
          if (bit_cnt == CW'(DW-1)) begin
            bit_cnt <= '0;
            oe_q    <= 1'b0;
            phase   <= PH_IDLE;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2: the drive window opens with the turnaround zero
  assert_turn_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);
  // R2: the window closes only when the frame is over
  assert_window_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> phase == PH_IDLE);
  // R3: the line is driven only for a read to this device
  assert_drive_own_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (hit_q && is_read));
endmodule

// File: rtl/mdio_irq_ctl.sv
module mdio_irq_ctl
  import mdio_slave_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt,
  input  logic             en_wr,
  input  logic [EVT_W-1:0] en_data,
  input  logic             rd_clr,
  input  logic             act_high,
  output logic [DW-1:0]    irq_word,
  output logic             irq_pin
);
  logic [EVT_W-1:0] en_q, status_q;
  logic             pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      status_q <= '0;
    end else begin
      if (en_wr) en_q <= en_data;
      status_q <= status_next(status_q, evt, rd_clr);
    end
  end

  assign pending  = |(status_q & en_q);
  assign irq_pin  = irq_level(pending, act_high);
  assign irq_word = {en_q, status_q};

  // R6: without a clearing read no status bit drops
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> (status_q & $past(status_q)) == $past(status_q));
  // R7: after the clearing edge only that edge's events remain
  assert_clear_keeps_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> status_q == $past(evt));
  // R8: a new pending interrupt moves the pin to the active level
  assert_pin_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pending) && $stable(act_high)) |-> irq_pin == act_high);
endmodule

// File: rtl/mdio_reg_store.sv
module mdio_reg_store
  import mdio_slave_pkg::*;
#(
  parameter int LO_LAST  = 6,
  parameter int HI_FIRST = 25,
  parameter int IRQ_ADDR = 27,
  parameter int POL_ADDR = 31,
  parameter int POL_BIT  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic          wr_go,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] irq_word,
  output logic [DW-1:0] rd_data,
  output logic          irq_en_wr,
  output logic          irq_rd_clr,
  output logic          act_high,
  output logic [DW-1:0] word0
);
  localparam int NREG = 1 << AW;
  localparam logic [AW-1:0] IRQ_A = AW'(IRQ_ADDR);

  logic [DW-1:0] word [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    if (reg_present(AW'(g), LO_LAST, HI_FIRST) && g != IRQ_ADDR) begin : g_flop
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= '0;
        else if (wr_go && addr == AW'(g))    q <= wr_data;
      end
      assign word[g] = q;
    end else begin : g_zero
      assign word[g] = '0;
    end
  end

  assign rd_data    = (addr == IRQ_A) ? irq_word : word[addr];
  assign irq_en_wr  = wr_go && (addr == IRQ_A);
  assign irq_rd_clr = rd_go && (addr == IRQ_A);
  assign act_high   = word[POL_ADDR][POL_BIT];
  assign word0      = word[0];

  // R5: an absent address presents zero to the serializer
  assert_absent_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !reg_present(addr, LO_LAST, HI_FIRST)) |-> rd_data == '0);
  // R4: a write to a populated plain register lands there
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && reg_present(addr, LO_LAST, HI_FIRST) && addr != IRQ_A)
      |=> word[$past(addr)] == $past(wr_data));
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slave_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int LO_LAST  = 6,
  parameter int HI_FIRST = 25,
  parameter int IRQ_ADDR = 27,
  parameter int POL_ADDR = 31,
  parameter int POL_BIT  = 9
) (
  input  logic             mdc,
  input  logic             rst_n,
  input  logic             mdio_in,
  input  logic [AW-1:0]    phy_addr,
  input  logic [EVT_W-1:0] core_evt,
  output logic             mdio_out,
  output logic             mdio_oe,
  output logic [DW-1:0]    basic_ctrl,
  output logic             irq_pin
);
  logic          rd_go, wr_go, irq_en_wr, irq_rd_clr, act_high;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] wr_data, rd_data, irq_word;

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .my_addr(phy_addr),
    .rd_data(rd_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .rd_go(rd_go), .wr_go(wr_go), .reg_addr(reg_addr), .wr_data(wr_data)
  );

  mdio_reg_store #(
    .LO_LAST(LO_LAST), .HI_FIRST(HI_FIRST), .IRQ_ADDR(IRQ_ADDR),
    .POL_ADDR(POL_ADDR), .POL_BIT(POL_BIT)
  ) u_store (
    .clk(mdc), .rst_n(rst_n), .rd_go(rd_go), .wr_go(wr_go), .addr(reg_addr),
    .wr_data(wr_data), .irq_word(irq_word), .rd_data(rd_data),
    .irq_en_wr(irq_en_wr), .irq_rd_clr(irq_rd_clr), .act_high(act_high),
    .word0(basic_ctrl)
  );

  mdio_irq_ctl u_irq (
    .clk(mdc), .rst_n(rst_n), .evt(core_evt), .en_wr(irq_en_wr),
    .en_data(wr_data[DW-1:EVT_W]), .rd_clr(irq_rd_clr), .act_high(act_high),
    .irq_word(irq_word), .irq_pin(irq_pin)
  );
endmodule

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;
  localparam int CLK_T = 10;
  localparam logic [4:0] MY_ADDR = 5'd11;

  logic mdc = 1'b0, rst_n = 1'b0;
  logic m_drv = 1'b0, m_bit = 1'b1;
  logic [7:0] evt = '0;
  logic mdio_out, mdio_oe, irq_pin, mdio_line;
  logic [15:0] basic_ctrl;

  assign mdio_line = m_drv ? m_bit : (mdio_oe ? mdio_out : 1'b1);

  mdio_mgmt_slave i_mdio_mgmt_slave (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_line), .phy_addr(MY_ADDR),
    .core_evt(evt), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .basic_ctrl(basic_ctrl), .irq_pin(irq_pin)
  );

  always #(CLK_T/2) mdc = ~mdc;

  int total = 0, bad = 0, cycles = 0;

  // behavioural model state
  logic [15:0] mregs [32];
  logic [7:0]  m_en = '0, m_st = '0;
  logic [15:0] rd_value = '0, cap = '0;
  bit          f_active = 0, f_rd = 0, f_match = 0;
  logic [4:0]  f_ra = '0;
  logic [15:0] f_wd = '0;
  int          f_idx = -1, oe_cnt = 0;
  logic [7:0]  prev_evt = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit present(input logic [4:0] a);
    return (a <= 5'd6) || (a >= 5'd25);
  endfunction

  function automatic logic [15:0] m_read(input logic [4:0] a);
    if (!present(a)) return '0;
    if (a == 5'd27) return {m_en, m_st};
    return mregs[a];
  endfunction

  function automatic logic exp_pin();
    logic pend;
    pend = |(m_en & m_st);
    return mregs[31][9] ? pend : !pend;
  endfunction

  // one period: apply effects of the last edge to the model, compare, drive next inputs
  task automatic tick(input logic drv, input logic b, input logic [7:0] e, input int idx);
    bit exp_oe;
    @(negedge mdc);
    if (f_active && f_rd && f_match && f_idx == 46) begin
      rd_value = m_read(f_ra);
      if (f_ra == 5'd27) m_st = '0;
    end
    m_st = m_st | prev_evt;
    if (f_active && !f_rd && f_match && f_idx == 63 && present(f_ra)) begin
      if (f_ra == 5'd27) m_en = f_wd[15:8];
      else mregs[f_ra] = f_wd;
    end
    exp_oe = f_active && f_rd && f_match && f_idx >= 46 && f_idx <= 62;
    if (mdio_oe) oe_cnt++;
    chk(mdio_oe == exp_oe, "R2 drive enable", 32'(mdio_oe), 32'(exp_oe));
    if (exp_oe && f_idx == 46) chk(mdio_out == 1'b0, "R2 turnaround zero", 32'(mdio_out), 0);
    if (exp_oe && f_idx >= 47) begin
      chk(mdio_out == rd_value[15-(f_idx-47)], "R1 data bit", 32'(mdio_out), 32'(rd_value[15-(f_idx-47)]));
      cap = {cap[14:0], mdio_out};
    end
    chk(irq_pin == exp_pin(), "R8 pin level", 32'(irq_pin), 32'(exp_pin()));
    chk(basic_ctrl == mregs[0], "R11 basic_ctrl", 32'(basic_ctrl), 32'(mregs[0]));
    m_drv = drv; m_bit = b; evt = e; f_idx = idx; prev_evt = e;
  endtask

  task automatic idle(input int n, input logic [7:0] e);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1, (i == 0) ? e : 8'h00, -1);
  endtask

  task automatic frame(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                       input logic [15:0] wd, input int pre, input logic [1:0] op,
                       input logic [7:0] ta_evt);
    logic b;
    f_active = (pre == 32) && (op == (rd ? 2'b10 : 2'b01));
    f_rd = rd; f_match = (phy == MY_ADDR); f_ra = ra; f_wd = wd;
    cap = '0; oe_cnt = 0;
    if (pre != 32) tick(1'b1, 1'b0, 8'h00, -1);
    for (int i = 0; i < pre; i++) tick(1'b1, 1'b1, 8'h00, -1);
    for (int k = 32; k < 64; k++) begin
      if (k == 32)      b = 1'b0;
      else if (k == 33) b = 1'b1;
      else if (k < 36)  b = op[35-k];
      else if (k < 41)  b = phy[40-k];
      else if (k < 46)  b = ra[45-k];
      else if (k == 46) b = 1'b1;
      else if (k == 47) b = 1'b0;
      else              b = wd[63-k];
      tick(!rd || k < 46, b, (k == 46) ? ta_evt : 8'h00, k);
    end
    idle(2, 8'h00);
    f_active = 0;
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    frame(1'b0, phy, ra, d, 32, 2'b01, 8'h00);
  endtask

  task automatic rd_exp(input logic [4:0] ra, input logic [15:0] exp, input string tag);
    frame(1'b1, MY_ADDR, ra, 16'h0, 32, 2'b10, 8'h00);
    chk(cap == exp, tag, 32'(cap), 32'(exp));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mregs[i] = '0;
    repeat (3) @(negedge mdc);
    // R10: reset state
    chk(mdio_oe == 1'b0, "R10 oe after reset", 32'(mdio_oe), 0);
    chk(irq_pin == 1'b1, "R10 pin after reset", 32'(irq_pin), 1);
    chk(basic_ctrl == 16'h0, "R10 ctrl after reset", 32'(basic_ctrl), 0);
    rst_n = 1'b1;
    idle(3, 8'h00);

    // R1 R4 R11: plain writes and reads, low and high parts of the map
    wr(MY_ADDR, 5'd0, 16'h1234);
    chk(basic_ctrl == 16'h1234, "R11 ctrl follows reg0", 32'(basic_ctrl), 32'h1234);
    rd_exp(5'd0, 16'h1234, "R1 read reg0");
    wr(MY_ADDR, 5'd26, 16'hBEEF);
    rd_exp(5'd26, 16'hBEEF, "R4 read reg26");
    chk(oe_cnt == 17, "R2 drive length", 32'(oe_cnt), 17);

    // R3: foreign address
    wr(5'd12, 5'd2, 16'hFFFF);
    frame(1'b1, 5'd3, 5'd26, 16'h0, 32, 2'b10, 8'h00);
    chk(oe_cnt == 0, "R3 no drive for other device", 32'(oe_cnt), 0);
    rd_exp(5'd2, 16'h0000, "R3 foreign write ignored");

    // R5: absent register
    wr(MY_ADDR, 5'd10, 16'h5555);
    rd_exp(5'd10, 16'h0000, "R5 absent reads zero");
    chk(oe_cnt == 17, "R5 absent still driven", 32'(oe_cnt), 17);

    // R9: short preamble and illegal opcode
    frame(1'b0, MY_ADDR, 5'd3, 16'h7777, 31, 2'b01, 8'h00);
    rd_exp(5'd3, 16'h0000, "R9 short preamble dropped");
    frame(1'b0, MY_ADDR, 5'd4, 16'h6666, 32, 2'b11, 8'h00);
    rd_exp(5'd4, 16'h0000, "R9 illegal opcode dropped");

    // R6: enable byte writable, status byte not
    wr(MY_ADDR, 5'd27, 16'hFFFF);
    rd_exp(5'd27, 16'hFF00, "R6 status not writable");
    idle(3, 8'h05);
    chk(irq_pin == 1'b0, "R8 active low pending", 32'(irq_pin), 0);
    // R7: read returns old status, event at the clearing edge survives
    frame(1'b1, MY_ADDR, 5'd27, 16'h0, 32, 2'b10, 8'h40);
    chk(cap == 16'hFF05, "R7 read before clear", 32'(cap), 32'hFF05);
    rd_exp(5'd27, 16'hFF40, "R7 same-edge event kept");
    rd_exp(5'd27, 16'hFF00, "R7 status cleared");
    chk(irq_pin == 1'b1, "R7 pin idle after clear", 32'(irq_pin), 1);

    // R8: polarity and enables
    idle(2, 8'h02);
    wr(MY_ADDR, 5'd31, 16'h0200);
    chk(irq_pin == 1'b1, "R8 active high pending", 32'(irq_pin), 1);
    rd_exp(5'd31, 16'h0200, "R4 read reg31");
    wr(MY_ADDR, 5'd27, 16'h00FF);
    chk(irq_pin == 1'b0, "R8 disabled not pending", 32'(irq_pin), 0);
    rd_exp(5'd27, 16'h0002, "R6 status sticky while disabled");

    idle(4, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge mdc) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule